// File: doc/BRIEF.md
# Pixel Rectangle Transfer Engine

This block moves a rectangle of 16-bit pixels between a 32-bit host word stream and an external pixel memory. The memory holds 2^X_W columns by 2^Y_W rows; the default is 1024 by 512. A start pulse loads the origin, the size and the direction. In the write direction the engine stores the two pixels carried by each accepted host word, one pixel per cycle. In the read direction each accepted host word is a request: the engine fetches two pixels and later returns them packed into one word.

Pixels run row-major through the rectangle. The first pixel of a word is in bits 15:0 and the second in bits 31:16. Both coordinates wrap at the memory edges. The host may stop offering words at any point, including in the middle of a row, and resume later without losing its place. While a write transfer runs, an optional mask setting forces the top bit of every stored pixel to 1.

Top module: `rect_xfer`

## Requirements
- R1: At start_i, the origin column is taken from pos_i[X_W-1:0] and the origin row from pos_i[16+Y_W-1:16]. All other bits of pos_i are ignored.
- R2: The width is size_i[X_W-1:0] and the height is size_i[16+Y_W-1:16]. A field value of 0 means the full memory width or height. All other bits of size_i are ignored.
- R3: Pixel number k of the rectangle goes to memory address row*2^X_W + column. Pixels run row-major. An even pixel comes from word bits 15:0 and an odd pixel from word bits 31:16.
- R4: The column of a pixel is (origin column + offset) modulo 2^X_W.
- R5: The row of a pixel is (origin row + row offset) modulo 2^Y_W.
- R6: While word_valid_i is low, no memory access takes place. The transfer then resumes at the pixel where it stopped, even in the middle of a row.
- R7: When set_mask_i is 1 at start_i, every pixel written during that transfer has bit 15 set. When it is 0, pixels are written unchanged.
- R8: In the read direction, rd_valid_o pulses once for each accepted word, in order. rd_data_o carries {second pixel, first pixel}. When the pixel count is odd, bits 31:16 of the final word are 0.
- R9: read_busy_o rises after a read start and falls when the last pixel is fetched. A write start leaves read_busy_o low.
- R10: done_o pulses for exactly one cycle when the last pixel of a transfer is handled. After that pulse busy_o and word_ready_o are low.
- R11: After reset, busy_o, word_ready_o, rd_valid_o, read_busy_o and done_o are all low.
- R12: When a write has an odd pixel count, bits 31:16 of the final word are discarded and touch no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load a new transfer |
| start_rd_i | input | 1 | Direction at start: 1 = read from memory, 0 = write to memory |
| set_mask_i | input | 1 | Force bit 15 of written pixels |
| pos_i | input | 32 | Origin word |
| size_i | input | 32 | Size word |
| word_valid_i | input | 1 | Host offers a word |
| word_data_i | input | 32 | Two pixels to write |
| word_ready_o | output | 1 | Engine takes a word this cycle |
| rd_valid_o | output | 1 | Readback word valid |
| rd_data_o | output | 32 | Readback word |
| busy_o | output | 1 | Transfer in progress |
| read_busy_o | output | 1 | Readback in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | X_W+Y_W | Pixel address |
| mem_we_o | output | 1 | Pixel write enable |
| mem_re_o | output | 1 | Pixel read enable |
| mem_wdata_o | output | 16 | Pixel write data |
| mem_rdata_i | input | 16 | Pixel read data, one cycle after mem_re_o |

## Verification
The assertions assume that start_i is never raised in the same cycle as the completion of a transfer. They also assume that the memory returns read data exactly one cycle after mem_re_o. The bench meets the first by starting a new transfer only after busy_o has dropped and a few idle cycles have passed. It meets the second with a single-cycle synchronous memory model. The stimulus offers words only when word_ready_o is high, and sweeps origins and sizes on a 32 by 16 memory. These include full-size and wrapping rectangles, odd pixel counts and pauses in the middle of a row.

// File: rtl/rect_pkg.sv
package rect_pkg;
  typedef enum logic {DIR_WR = 1'b0, DIR_RD = 1'b1} dir_e;
endpackage

// File: rtl/rect_coord.sv
module rect_coord #(
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [XW-1:0]    x0_i,
  input  logic [YW-1:0]    y0_i,
  input  logic [XW-1:0]    w_m1_i,
  input  logic [YW-1:0]    h_m1_i,
  input  logic             step_i,
  output logic [XW+YW-1:0] addr_o,
  output logic             active_o,
  output logic             last_o
);
  logic [XW-1:0] x0_q, col_q, wm1_q;
  logic [YW-1:0] y_q, rows_q;
  logic          act_q;
  logic          row_end;

  assign row_end  = (col_q == wm1_q);
  assign last_o   = act_q & row_end & (rows_q == '0);
  assign active_o = act_q;
  assign addr_o   = {y_q, XW'(x0_q + col_q)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x0_q   <= '0;
      col_q  <= '0;
      wm1_q  <= '0;
      y_q    <= '0;
      rows_q <= '0;
      act_q  <= 1'b0;
    end else if (load_i) begin
      x0_q   <= x0_i;
      col_q  <= '0;
      wm1_q  <= w_m1_i;
      y_q    <= y0_i;
      rows_q <= h_m1_i;
      act_q  <= 1'b1;
    end else if (step_i && act_q) begin
      if (row_end) begin
        col_q  <= '0;
        y_q    <= y_q + 1'b1;
        rows_q <= rows_q - 1'b1;
        if (rows_q == '0) act_q <= 1'b0;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rect_rd_pack.sv
module rect_rd_pack (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        re_i,
  input  logic        slot_i,
  input  logic        last_i,
  input  logic [15:0] rdata_i,
  output logic        valid_o,
  output logic [31:0] data_o
);
  logic        re_q, slot_q, last_q;
  logic [15:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_q    <= 1'b0;
      slot_q  <= 1'b0;
      last_q  <= 1'b0;
      lo_q    <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      re_q    <= re_i;
      slot_q  <= slot_i;
      last_q  <= last_i;
      valid_o <= 1'b0;
      if (re_q) begin
        if (slot_q) begin
          valid_o <= 1'b1;
          data_o  <= {rdata_i, lo_q};
        end else if (last_q) begin
          valid_o <= 1'b1;
          data_o  <= {16'h0000, rdata_i};
        end else begin
          lo_q <= rdata_i;
        end
      end
    end
  end
endmodule

// File: rtl/rect_xfer.sv
module rect_xfer
  import rect_pkg::*;
#(
  parameter int X_W = 10,
  parameter int Y_W = 9,
  localparam int AW = X_W + Y_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          start_rd_i,
  input  logic          set_mask_i,
  input  logic [31:0]   pos_i,
  input  logic [31:0]   size_i,
  input  logic          word_valid_i,
  input  logic [31:0]   word_data_i,
  output logic          word_ready_o,
  output logic          rd_valid_o,
  output logic [31:0]   rd_data_o,
  output logic          busy_o,
  output logic          read_busy_o,
  output logic          done_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic [15:0]   mem_wdata_o,
  input  logic [15:0]   mem_rdata_i
);
  dir_e          dir_q;
  logic          mask_q, phase_q, rbusy_q, done_q;
  logic [15:0]   hi_q;
  logic          active, last, step;
  logic [X_W-1:0] w_m1;
  logic [Y_W-1:0] h_m1;

  // zero field wraps to full extent
  assign w_m1 = size_i[X_W-1:0] - {{(X_W-1){1'b0}}, 1'b1};
  assign h_m1 = size_i[16 +: Y_W] - {{(Y_W-1){1'b0}}, 1'b1};

  rect_coord #(.XW(X_W), .YW(Y_W)) u_coord (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start_i),
    .x0_i     (pos_i[X_W-1:0]),
    .y0_i     (pos_i[16 +: Y_W]),
    .w_m1_i   (w_m1),
    .h_m1_i   (h_m1),
    .step_i   (step),
    .addr_o   (mem_addr_o),
    .active_o (active),
    .last_o   (last)
  );

  assign step         = active & ~start_i & (phase_q | word_valid_i);
  assign mem_we_o     = step & (dir_q == DIR_WR);
  assign mem_re_o     = step & (dir_q == DIR_RD);
  assign mem_wdata_o  = (phase_q ? hi_q : word_data_i[15:0]) | {mask_q, 15'h0000};
  assign word_ready_o = active & ~phase_q & ~start_i;
  assign busy_o       = active;
  assign read_busy_o  = rbusy_q;
  assign done_o       = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= DIR_WR;
      mask_q  <= 1'b0;
      phase_q <= 1'b0;
      hi_q    <= '0;
      rbusy_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (start_i) begin
      dir_q   <= start_rd_i ? DIR_RD : DIR_WR;
      mask_q  <= set_mask_i & ~start_rd_i;
      phase_q <= 1'b0;
      rbusy_q <= start_rd_i;
      done_q  <= 1'b0;
    end else begin
      done_q <= step & last;
      if (step) begin
        if (!phase_q && !last) begin
          phase_q <= 1'b1;
          hi_q    <= word_data_i[31:16];
        end else begin
          phase_q <= 1'b0;
        end
        if (last) rbusy_q <= 1'b0;
      end
    end
  end

  rect_rd_pack u_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .re_i    (mem_re_o),
    .slot_i  (phase_q),
    .last_i  (last),
    .rdata_i (mem_rdata_i),
    .valid_o (rd_valid_o),
    .data_o  (rd_data_o)
  );
endmodule

// File: rtl/rect_xfer_chk.sv
module rect_xfer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        start_rd_i,
  input logic        set_mask_i,
  input logic        word_valid_i,
  input logic        word_ready_o,
  input logic        busy_o,
  input logic        read_busy_o,
  input logic        done_o,
  input logic        mem_we_o,
  input logic        mem_re_o,
  input logic [15:0] mem_wdata_o
);
  logic mask_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_seen <= 1'b0;
    else if (start_i) mask_seen <= set_mask_i & ~start_rd_i;
  end

  AST_MASK_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && mask_seen |-> mem_wdata_o[15]) else $error("mask"); // R7

  AST_NO_WRITE_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_busy_o |-> !mem_we_o) else $error("write during read"); // R9

  AST_READ_BUSY_NESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_busy_o |-> busy_o) else $error("read busy"); // R9

  AST_IDLE_NO_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !word_ready_o && !mem_we_o && !mem_re_o) else $error("idle"); // R10

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !$past(start_i) |-> !busy_o) else $error("done"); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done width"); // R10

  AST_PAUSE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_ready_o && !word_valid_i |-> !mem_we_o && !mem_re_o) else $error("pause"); // R6
endmodule

bind rect_xfer rect_xfer_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .start_rd_i   (start_rd_i),
  .set_mask_i   (set_mask_i),
  .word_valid_i (word_valid_i),
  .word_ready_o (word_ready_o),
  .busy_o       (busy_o),
  .read_busy_o  (read_busy_o),
  .done_o       (done_o),
  .mem_we_o     (mem_we_o),
  .mem_re_o     (mem_re_o),
  .mem_wdata_o  (mem_wdata_o)
);

// File: tb/tb_rect_xfer.sv
module tb_rect_xfer;
  localparam int XW = 5;
  localparam int YW = 4;
  localparam int NX = 1 << XW;
  localparam int NY = 1 << YW;
  localparam int NPIX = NX * NY;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, start_rd_i = 1'b0, set_mask_i = 1'b0;
  logic [31:0] pos_i = '0, size_i = '0;
  logic        word_valid_i = 1'b0;
  logic [31:0] word_data_i = '0;
  logic        word_ready_o, rd_valid_o, busy_o, read_busy_o, done_o;
  logic [31:0] rd_data_o;
  logic [XW+YW-1:0] mem_addr_o;
  logic        mem_we_o, mem_re_o;
  logic [15:0] mem_wdata_o, mem_rdata_i;

  logic [15:0] ram [NPIX];
  logic [15:0] expm [NPIX];
  logic [31:0] rdq [NPIX];
  int rdn = 0, done_cnt = 0, errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  rect_xfer #(.X_W(XW), .Y_W(YW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .start_rd_i(start_rd_i),
    .set_mask_i(set_mask_i), .pos_i(pos_i), .size_i(size_i),
    .word_valid_i(word_valid_i), .word_data_i(word_data_i), .word_ready_o(word_ready_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .busy_o(busy_o),
    .read_busy_o(read_busy_o), .done_o(done_o), .mem_addr_o(mem_addr_o),
    .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i)
  );

  always @(posedge clk) begin
    if (mem_we_o) ram[mem_addr_o] <= mem_wdata_o;
    mem_rdata_i <= ram[mem_addr_o];
  end

  always @(negedge clk) begin
    if (done_o) done_cnt <= done_cnt + 1;
    if (rd_valid_o && rdn < NPIX) begin
      rdq[rdn] <= rd_data_o;
      rdn <= rdn + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pix_of(input int seed, input int k);
    return 16'((seed * 97 + k * 5 + 3) & 16'h7fff);
  endfunction

  task automatic xfer(input bit rd, input int x, input int y, input int wf, input int hf,
                      input bit mk, input int gap, input int seed, input string req);
    int w, h, npx, nw, d0, bad, first_a;
    logic [31:0] fa, fe;
    w = (wf == 0) ? NX : wf;
    h = (hf == 0) ? NY : hf;
    npx = w * h;
    nw = (npx + 1) / 2;
    d0 = done_cnt;
    @(negedge clk);
    start_i = 1'b1; start_rd_i = rd; set_mask_i = mk;
    pos_i  = 32'h8000_ffe0 | (y << 16) | x;   // junk in ignored bits (R1)
    size_i = 32'hfff0_ffe0 | (hf << 16) | wf; // junk in ignored bits (R2)
    @(negedge clk);
    start_i = 1'b0;
    rdn = 0;
    chk(read_busy_o == rd, "R9 read_busy after start", {31'b0, read_busy_o}, {31'b0, rd});
    for (int k = 0; k < nw; k++) begin
      if (gap != 0 && (k % gap) == 1) repeat (3) @(negedge clk); // pause, often mid-row (R6)
      while (!word_ready_o) @(negedge clk);
      word_valid_i = 1'b1;
      word_data_i = {pix_of(seed, 2 * k + 1), pix_of(seed, 2 * k)};
      @(negedge clk);
      word_valid_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(done_cnt == d0 + 1, "R10 single done pulse", 32'(done_cnt - d0), 32'd1);
    chk(!busy_o && !word_ready_o && !read_busy_o, "R10 R9 idle after done",
        {29'b0, busy_o, word_ready_o, read_busy_o}, 32'd0);
    bad = 0; fa = '0; fe = '0; first_a = 1;
    if (!rd) begin
      for (int p = 0; p < npx; p++) begin
        int a;
        a = ((y + p / w) % NY) * NX + ((x + p % w) % NX);
        expm[a] = pix_of(seed, p) | (mk ? 16'h8000 : 16'h0000);
      end
      for (int a = 0; a < NPIX; a++)
        if (ram[a] !== expm[a]) begin
          if (first_a == 1) begin fa = {16'(a), ram[a]}; fe = {16'(a), expm[a]}; first_a = 0; end
          bad++;
        end
      chk(bad == 0, req, fa, fe);
    end else begin
      chk(rdn == nw, {req, " R8 word count"}, 32'(rdn), 32'(nw));
      for (int j = 0; j < nw && j < rdn; j++) begin
        logic [15:0] lo, hi;
        int p0;
        p0 = 2 * j;
        lo = expm[((y + p0 / w) % NY) * NX + ((x + p0 % w) % NX)];
        hi = 16'h0000;
        if (p0 + 1 < npx) hi = expm[((y + (p0 + 1) / w) % NY) * NX + ((x + (p0 + 1) % w) % NX)];
        if (rdq[j] !== {hi, lo}) begin
          if (first_a == 1) begin fa = rdq[j]; fe = {hi, lo}; first_a = 0; end
          bad++;
        end
      end
      chk(bad == 0, req, fa, fe);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int a = 0; a < NPIX; a++) begin
      ram[a] = 16'(a * 3 + 1);
      expm[a] = 16'(a * 3 + 1);
    end
    repeat (3) @(negedge clk);
    chk(!busy_o && !word_ready_o && !rd_valid_o && !read_busy_o && !done_o, "R11 reset state",
        {27'b0, busy_o, word_ready_o, rd_valid_o, read_busy_o, done_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !done_o, "R11 idle after reset", {30'b0, busy_o, done_o}, 32'd0);

    xfer(1'b0, 4, 3, 3, 2, 1'b0, 0, 1, "R1 R2 R3 basic write");
    xfer(1'b0, 30, 14, 5, 4, 1'b1, 0, 2, "R4 R5 R7 wrapping masked write");
    xfer(1'b0, 9, 6, 7, 3, 1'b0, 2, 3, "R6 paused write");
    xfer(1'b0, 1, 1, 3, 1, 1'b0, 0, 4, "R12 odd count write");
    xfer(1'b0, 7, 5, 0, 0, 1'b0, 3, 5, "R2 full size write");
    xfer(1'b0, 20, 10, 6, 3, 1'b1, 0, 6, "R7 masked write");
    xfer(1'b1, 29, 15, 5, 3, 1'b0, 0, 0, "R8 R4 R5 wrapping read");
    xfer(1'b1, 2, 2, 3, 3, 1'b0, 2, 0, "R8 R6 paused odd read");
    xfer(1'b1, 0, 0, 0, 0, 1'b0, 0, 0, "R8 R2 full read");
    for (int s = 1; s <= 8; s++)
      xfer(1'b0, (s * 11) % NX, (s * 5) % NY, s, 9 - s, s[0], s % 3, 10 + s, "R3 R4 R5 size sweep");
    for (int s = 1; s <= 8; s++)
      xfer(1'b1, (s * 7) % NX, (s * 3) % NY, 9 - s, s, 1'b0, s % 4, 0, "R8 size sweep read");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule